// File: doc/BRIEF.md
# CAN Configuration-Lock Sequencer

This block decides when a CAN controller may be taken off the bus so that software can rewrite its configuration. Software writes a request bit. A request to lock does not take effect at once. It waits until the bit engine reports no reception, transmission or arbitration, or until an error event cuts that activity short. Only then does the visible lock flag rise. While the flag is high, the bit engine is held off the bus. Writes to the low protected configuration bytes and to the two error-count registers are passed through only while the flag is high.

Several conditions override software. A bus-off condition drops the lock and starts a recovery wait, and software writes to the request bit are ignored while it lasts. A controller soft reset forces the lock on, and so does a pair of all-zero bit-timing values; while both timing values are zero, a request to unlock is refused. After any unlock or bus-off recovery, the node stays off the bus until it has sampled a run of consecutive recessive bits. A separate flag reports when either error counter is above a selectable threshold.

Top module: `canlock_seq`

## Requirements
- R1: After reset, cfg_lock is 1, bus_disable is 1 and no lock request is pending.
- R2: A lock request (req_wr pulse with req_val=1) made while any of rx_busy, tx_busy or arb_busy is 1 leaves cfg_lock at 0 for as long as that activity lasts and err_evt stays 0.
- R3: A pending lock request sets cfg_lock on the first clock edge at which all three activity inputs are 0 or err_evt is 1. A request made while idle sets cfg_lock on the edge that samples it.
- R4: cfg_wr_en equals cfg_wr for cfg_addr of 16 or more. For cfg_addr 0 to 15 it equals cfg_wr only while cfg_lock is 1, and is 0 otherwise. The compare and the gating are both combinational.
- R5: cnt_wr_en equals cnt_wr while cfg_lock is 1 and is 0 otherwise.
- R6: While bus_off is 1 (and soft_rst is 0), cfg_lock is 0 from the next edge on, bus_disable is 1, and req_wr pulses of either value have no effect.
- R7: soft_rst=1 sets cfg_lock on the next edge and takes priority over bus_off. When bus_off is 0, timing0 = timing1 = 00h also sets cfg_lock on the next edge.
- R8: A clear request (req_wr pulse with req_val=0) is refused while both timing values are 00h. It is accepted when only one of them is zero.
- R9: A clear request while locked drops cfg_lock on the next edge. bus_disable then stays 1 until 11 consecutive bit_tick strobes have sampled bus_dominant=0, and falls on the edge of the 11th. A strobe with bus_dominant=1 restarts the count.
- R10: bus_disable is 1 on every cycle in which cfg_lock is 1.
- R11: A clear request made while a lock request is still pending cancels it, and cfg_lock stays 0 when the activity later stops.
- R12: err_exceeded is 1 when tec or rec is above 9 with thr_sel=0, or above 127 with thr_sel=1, and is 0 otherwise.
- R13: After bus_off returns to 0, bus_disable stays 1 until the recessive-bit wait of R9 completes, and cfg_lock stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Controller soft-reset bit, forces lock |
| timing0 | input | 8 | First bit-timing register value |
| timing1 | input | 8 | Second bit-timing register value |
| req_wr | input | 1 | One-cycle software write strobe to the lock bit |
| req_val | input | 1 | Value written: 1 requests lock, 0 requests release |
| rx_busy | input | 1 | Reception in progress |
| tx_busy | input | 1 | Transmission in progress |
| arb_busy | input | 1 | Arbitration in progress |
| err_evt | input | 1 | One-cycle bus error event |
| bus_off | input | 1 | Bus-off condition present |
| bit_tick | input | 1 | One-cycle strobe per sampled bit time |
| bus_dominant | input | 1 | Sampled bus level, 1 = dominant |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cnt_wr | input | 1 | Error-count register write strobe |
| thr_sel | input | 1 | Threshold select: 0 = above 9, 1 = above 127 |
| tec | input | 8 | Transmit error count |
| rec | input | 8 | Receive error count |
| cfg_lock | output | 1 | Effective lock flag |
| bus_disable | output | 1 | Keeps the bit engine off the bus |
| cfg_wr_en | output | 1 | Gated configuration byte write |
| cnt_wr_en | output | 1 | Gated error-count register write |
| err_exceeded | output | 1 | Error count above the selected threshold |

## Verification
The assertions check, on every cycle, the properties that relate signals across a single edge. A rising lock flag must follow idle activity, an error event or a forcing condition. Bus-off, soft reset and zero timing each force the flag. Write gating and counter gating must agree with the flag. bus_disable must cover the flag. A dominant strobe must not end the rejoin wait. Other behaviour only shows up over whole scenarios driven by the bench. This covers the full 11-bit recessive run and its restart after a dominant bit, cancelling a pending request, refusal to unlock with zero timing, and the recovery wait after bus-off. A behavioural model in the bench is compared against every output on every clock.

// File: rtl/canlock_pkg.sv
package canlock_pkg;

   typedef struct packed {
      logic rx;
      logic tx;
      logic arb;
   } canlock_act_t;

   typedef enum logic [1:0] {
      LK_RUN  = 2'd0,
      LK_PEND = 2'd1,
      LK_HELD = 2'd2
   } canlock_state_e;

endpackage

// File: rtl/canlock_ctrl.sv
module canlock_ctrl
   import canlock_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         soft_rst,
   input  logic         bus_off,
   input  logic         timing_zero,
   input  logic         req_wr,
   input  logic         req_val,
   input  logic         err_evt,
   input  canlock_act_t act,
   output logic         locked,
   output logic         rj_start,
   output logic         rj_abort
);

   canlock_state_e state_q, state_d;
   logic idle, clr_req, set_req, unlocked, want, grant, release_req;

   always_comb begin
      idle        = ~(act.rx | act.tx | act.arb);
      clr_req     = req_wr & ~req_val;
      set_req     = req_wr & req_val;
      unlocked    = (state_q != LK_HELD);
      want        = unlocked & (set_req | (state_q == LK_PEND)) & ~clr_req;
      grant       = want & (idle | err_evt);
      release_req = clr_req & ~unlocked;
   end

   always_comb begin
      state_d  = state_q;
      rj_start = 1'b0;
      rj_abort = 1'b0;
      if (soft_rst) begin
         state_d  = LK_HELD;
         rj_abort = 1'b1;
      end else if (bus_off) begin
         state_d  = LK_RUN;
         rj_start = 1'b1;
      end else if (timing_zero || grant) begin
         state_d  = LK_HELD;
         rj_abort = 1'b1;
      end else if (release_req) begin
         state_d  = LK_RUN;
         rj_start = 1'b1;
      end else if (unlocked) begin
         state_d  = want ? LK_PEND : LK_RUN;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= LK_HELD;
      else        state_q <= state_d;
   end

   assign locked = (state_q == LK_HELD);

   // R2 and R3: the flag only rises after idle activity, an error or a forcing input
   assert_defer_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(idle | err_evt | soft_rst | timing_zero));

   assert_busoff_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_off && !soft_rst) |=> !locked);

   assert_force_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_rst || (timing_zero && !bus_off)) |=> locked);

   assert_zero_refuse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && timing_zero && !bus_off && clr_req) |=> locked);

   assert_cancel_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == LK_PEND) && clr_req && !soft_rst && !bus_off && !timing_zero) |=> !locked);

endmodule

// File: rtl/canlock_rejoin.sv
module canlock_rejoin #(
   parameter int REJOIN_BITS = 11
) (
   input  logic clk,
   input  logic rst_n,
   input  logic abort,
   input  logic start,
   input  logic bit_tick,
   input  logic bus_dominant,
   output logic waiting
);

   localparam int CW = $clog2(REJOIN_BITS);
   localparam logic [CW-1:0] LAST = CW'(REJOIN_BITS - 1);

   if (REJOIN_BITS < 2) begin : g_bad_rejoin
      $error("canlock_rejoin: REJOIN_BITS must be at least 2");
   end

   logic [CW-1:0] cnt_q;
   logic          wait_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wait_q <= 1'b0;
         cnt_q  <= '0;
      end else if (abort) begin
         wait_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start) begin
         wait_q <= 1'b1;
         cnt_q  <= '0;
      end else if (wait_q && bit_tick) begin
         if (bus_dominant) begin
            cnt_q <= '0;
         end else if (cnt_q == LAST) begin
            wait_q <= 1'b0;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + CW'(1);
         end
      end
   end

   assign waiting = wait_q;

   assert_dominant_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (waiting && bit_tick && bus_dominant && !abort) |=> waiting);

   assert_end_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(waiting) && !$past(abort)) |-> $past(bit_tick && !bus_dominant));

endmodule

// File: rtl/canlock_gate.sv
module canlock_gate #(
   parameter int ADDR_W     = 8,
   parameter int PROT_BYTES = 16,
   parameter int CNT_W      = 8,
   parameter int THR_LO     = 9,
   parameter int THR_HI     = 127
) (
   input  logic              locked,
   input  logic              cfg_wr,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic              cnt_wr,
   input  logic              thr_sel,
   input  logic [CNT_W-1:0]  tec,
   input  logic [CNT_W-1:0]  rec,
   output logic              cfg_wr_en,
   output logic              cnt_wr_en,
   output logic              err_exceeded
);

   localparam int PB_LOG = $clog2(PROT_BYTES);

   if (PROT_BYTES < 1 || PROT_BYTES >= (1 << ADDR_W)) begin : g_bad_prot
      $error("canlock_gate: PROT_BYTES must lie within the address space");
   end
   if (THR_LO >= THR_HI || THR_HI >= (1 << CNT_W)) begin : g_bad_thr
      $error("canlock_gate: thresholds must be ordered and fit CNT_W");
   end

   logic in_prot;

   if ((PROT_BYTES & (PROT_BYTES - 1)) == 0) begin : g_pow2
      assign in_prot = ~|cfg_addr[ADDR_W-1:PB_LOG];
   end else begin : g_cmp
      assign in_prot = (cfg_addr < ADDR_W'(PROT_BYTES));
   end

   logic [CNT_W-1:0] thr;

   always_comb begin
      thr          = thr_sel ? CNT_W'(THR_HI) : CNT_W'(THR_LO);
      err_exceeded = (tec > thr) | (rec > thr);
      cfg_wr_en    = cfg_wr & (locked | ~in_prot);
      cnt_wr_en    = cnt_wr & locked;
   end

endmodule

// File: rtl/canlock_seq.sv
module canlock_seq
   import canlock_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int PROT_BYTES  = 16,
   parameter int CNT_W       = 8,
   parameter int TIM_W       = 8,
   parameter int THR_LO      = 9,
   parameter int THR_HI      = 127,
   parameter int REJOIN_BITS = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic [TIM_W-1:0]  timing0,
   input  logic [TIM_W-1:0]  timing1,
   input  logic              req_wr,
   input  logic              req_val,
   input  logic              rx_busy,
   input  logic              tx_busy,
   input  logic              arb_busy,
   input  logic              err_evt,
   input  logic              bus_off,
   input  logic              bit_tick,
   input  logic              bus_dominant,
   input  logic              cfg_wr,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic              cnt_wr,
   input  logic              thr_sel,
   input  logic [CNT_W-1:0]  tec,
   input  logic [CNT_W-1:0]  rec,
   output logic              cfg_lock,
   output logic              bus_disable,
   output logic              cfg_wr_en,
   output logic              cnt_wr_en,
   output logic              err_exceeded
);

   canlock_act_t act;
   logic timing_zero, rj_start, rj_abort, waiting;

   assign act         = '{rx: rx_busy, tx: tx_busy, arb: arb_busy};
   assign timing_zero = ~|timing0 & ~|timing1;

   canlock_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .soft_rst    (soft_rst),
      .bus_off     (bus_off),
      .timing_zero (timing_zero),
      .req_wr      (req_wr),
      .req_val     (req_val),
      .err_evt     (err_evt),
      .act         (act),
      .locked      (cfg_lock),
      .rj_start    (rj_start),
      .rj_abort    (rj_abort)
   );

   canlock_rejoin #(.REJOIN_BITS(REJOIN_BITS)) u_rejoin (
      .clk          (clk),
      .rst_n        (rst_n),
      .abort        (rj_abort),
      .start        (rj_start),
      .bit_tick     (bit_tick),
      .bus_dominant (bus_dominant),
      .waiting      (waiting)
   );

   canlock_gate #(
      .ADDR_W     (ADDR_W),
      .PROT_BYTES (PROT_BYTES),
      .CNT_W      (CNT_W),
      .THR_LO     (THR_LO),
      .THR_HI     (THR_HI)
   ) u_gate (
      .locked       (cfg_lock),
      .cfg_wr       (cfg_wr),
      .cfg_addr     (cfg_addr),
      .cnt_wr       (cnt_wr),
      .thr_sel      (thr_sel),
      .tec          (tec),
      .rec          (rec),
      .cfg_wr_en    (cfg_wr_en),
      .cnt_wr_en    (cnt_wr_en),
      .err_exceeded (err_exceeded)
   );

   assign bus_disable = cfg_lock | waiting;

   assert_protect_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr_en && (cfg_addr < ADDR_W'(PROT_BYTES))) |-> cfg_lock);

   assert_cnt_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr_en |-> cfg_lock);

   assert_cover_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_lock |-> bus_disable);

   assert_low_thr_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!thr_sel && tec <= CNT_W'(THR_LO) && rec <= CNT_W'(THR_LO)) |-> !err_exceeded);

   assert_high_thr_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_sel && (tec > CNT_W'(THR_HI) || rec > CNT_W'(THR_HI))) |-> err_exceeded);

   assert_busoff_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_off && !soft_rst) |=> bus_disable);

endmodule

// File: tb/tb_canlock_seq.sv
`timescale 1ns/100ps
module tb_canlock_seq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       soft_rst = 0, req_wr = 0, req_val = 0;
   logic       rx_busy = 0, tx_busy = 0, arb_busy = 0, err_evt = 0, bus_off = 0;
   logic       bit_tick = 0, bus_dominant = 0, cfg_wr = 0, cnt_wr = 0, thr_sel = 0;
   logic [7:0] timing0 = 8'h12, timing1 = 8'h34, cfg_addr = 0, tec = 0, rec = 0;
   logic       cfg_lock, bus_disable, cfg_wr_en, cnt_wr_en, err_exceeded;

   int nchk = 0, nerr = 0;

   always #2 clk = ~clk;

   canlock_seq dut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .timing0(timing0), .timing1(timing1),
      .req_wr(req_wr), .req_val(req_val), .rx_busy(rx_busy), .tx_busy(tx_busy),
      .arb_busy(arb_busy), .err_evt(err_evt), .bus_off(bus_off), .bit_tick(bit_tick),
      .bus_dominant(bus_dominant), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cnt_wr(cnt_wr),
      .thr_sel(thr_sel), .tec(tec), .rec(rec), .cfg_lock(cfg_lock),
      .bus_disable(bus_disable), .cfg_wr_en(cfg_wr_en), .cnt_wr_en(cnt_wr_en),
      .err_exceeded(err_exceeded)
   );

   // behavioural reference model
   bit m_lock = 1, m_pend = 0, m_wait = 0;
   int m_run = 0;

   always @(posedge clk) begin
      bit quiet, zero_tim, ask;
      if (!rst_n) begin
         m_lock = 1; m_pend = 0; m_wait = 0; m_run = 0;
      end else begin
         quiet    = !(rx_busy || tx_busy || arb_busy);
         zero_tim = (timing0 == 0) && (timing1 == 0);
         ask      = !m_lock && (m_pend || (req_wr && req_val)) && !(req_wr && !req_val);
         if (soft_rst) begin
            m_lock = 1; m_pend = 0; m_wait = 0; m_run = 0;
         end else if (bus_off) begin
            m_lock = 0; m_pend = 0; m_wait = 1; m_run = 0;
         end else if (zero_tim || (ask && (quiet || err_evt))) begin
            m_lock = 1; m_pend = 0; m_wait = 0; m_run = 0;
         end else if (req_wr && !req_val && m_lock) begin
            m_lock = 0; m_wait = 1; m_run = 0;
         end else begin
            m_pend = ask;
            if (m_wait && bit_tick) begin
               if (bus_dominant) m_run = 0;
               else begin
                  m_run++;
                  if (m_run == 11) begin m_wait = 0; m_run = 0; end
               end
            end
         end
      end
   end

   task automatic chk(string tag, logic act, logic exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      bit thr_hit;
      int thr;
      thr     = thr_sel ? 127 : 9;
      thr_hit = (int'(tec) > thr) || (int'(rec) > thr);
      chk("R3 model cfg_lock", cfg_lock, m_lock);
      chk("R9 model bus_disable", bus_disable, m_lock || m_wait);
      chk("R4 model cfg_wr_en", cfg_wr_en, cfg_wr && (cfg_addr >= 16 || m_lock));
      chk("R5 model cnt_wr_en", cnt_wr_en, cnt_wr && m_lock);
      chk("R12 model err_exceeded", err_exceeded, thr_hit);
   end

   task automatic cyc(int n = 1);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic look;
      #0.5;
   endtask

   task automatic pulse_req(bit v);
      req_wr = 1; req_val = v;
      cyc();
      req_wr = 0;
      look();
   endtask

   task automatic rtick(bit dom);
      bit_tick = 1; bus_dominant = dom;
      cyc();
      bit_tick = 0; bus_dominant = 0;
      cyc();
      look();
   endtask

   task automatic rejoin_run(int n);
      for (int i = 0; i < n; i++) rtick(0);
   endtask

   initial begin
      #800000;
      nerr++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      cyc(3); look();
      chk("R1 reset lock", cfg_lock, 1);
      chk("R1 reset bus_disable", bus_disable, 1);
      rst_n = 1;
      cyc(); look();
      chk("R1 lock after reset release", cfg_lock, 1);
      cfg_wr = 1; cfg_addr = 5; look();
      chk("R4 protected write while locked", cfg_wr_en, 1);
      cnt_wr = 1; look();
      chk("R5 counter write while locked", cnt_wr_en, 1);
      cfg_wr = 0; cnt_wr = 0;

      // release and rejoin wait
      pulse_req(0);
      chk("R9 lock drops on clear", cfg_lock, 0);
      chk("R9 still disabled", bus_disable, 1);
      cfg_wr = 1; cfg_addr = 5; look();
      chk("R4 protected write dropped", cfg_wr_en, 0);
      cfg_addr = 16; look();
      chk("R4 address 16 passes", cfg_wr_en, 1);
      cfg_addr = 8'hFF; look();
      chk("R4 top address passes", cfg_wr_en, 1);
      cfg_addr = 15; look();
      chk("R4 address 15 dropped", cfg_wr_en, 0);
      cfg_wr = 0; cnt_wr = 1; look();
      chk("R5 counter write dropped", cnt_wr_en, 0);
      cnt_wr = 0;
      rejoin_run(6);
      rtick(1);
      rejoin_run(10);
      chk("R9 ten recessive after dominant", bus_disable, 1);
      rtick(0);
      chk("R9 eleventh recessive ends wait", bus_disable, 0);

      // deferred lock through activity
      rx_busy = 1;
      pulse_req(1);
      chk("R2 rx busy defers", cfg_lock, 0);
      cyc(3); look();
      chk("R2 still deferred", cfg_lock, 0);
      rx_busy = 0; tx_busy = 1; cyc(); look();
      chk("R2 tx busy defers", cfg_lock, 0);
      tx_busy = 0; arb_busy = 1; cyc(); look();
      chk("R2 arb busy defers", cfg_lock, 0);
      arb_busy = 0; cyc(); look();
      chk("R3 granted when idle", cfg_lock, 1);
      chk("R10 disable covers lock", bus_disable, 1);

      // error grants
      pulse_req(0);
      tx_busy = 1;
      pulse_req(1);
      cyc(2); look();
      chk("R2 busy before error", cfg_lock, 0);
      err_evt = 1; cyc(); err_evt = 0; look();
      chk("R3 error grants lock", cfg_lock, 1);
      tx_busy = 0;

      // idle request locks at once
      pulse_req(0);
      pulse_req(1);
      chk("R3 idle request immediate", cfg_lock, 1);

      // cancel pending
      pulse_req(0);
      arb_busy = 1;
      pulse_req(1);
      cyc(2);
      pulse_req(0);
      arb_busy = 0;
      cyc(3); look();
      chk("R11 cancelled request stays off", cfg_lock, 0);

      // bus-off
      pulse_req(1);
      chk("R3 lock before bus-off", cfg_lock, 1);
      bus_off = 1; cyc(); look();
      chk("R6 bus-off clears lock", cfg_lock, 0);
      chk("R6 bus-off disables", bus_disable, 1);
      pulse_req(1);
      cyc(2); look();
      chk("R6 request ignored in bus-off", cfg_lock, 0);
      rtick(0);
      bus_off = 0; cyc(); look();
      chk("R13 lock stays off after bus-off", cfg_lock, 0);
      chk("R13 recovery wait", bus_disable, 1);
      rejoin_run(10);
      chk("R13 ten recessive not enough", bus_disable, 1);
      rtick(0);
      chk("R13 rejoined", bus_disable, 0);

      // zero timing
      timing0 = 0; timing1 = 0; cyc(); look();
      chk("R7 zero timing forces lock", cfg_lock, 1);
      pulse_req(0);
      cyc(2); look();
      chk("R8 clear refused with zero timing", cfg_lock, 1);
      timing1 = 8'h05;
      pulse_req(0);
      chk("R8 clear accepted with one zero", cfg_lock, 0);

      // soft reset and priority
      soft_rst = 1; cyc(); look();
      chk("R7 soft reset forces lock", cfg_lock, 1);
      bus_off = 1; cyc(); look();
      chk("R7 soft reset beats bus-off", cfg_lock, 1);
      soft_rst = 0; cyc(); look();
      chk("R6 bus-off after soft reset", cfg_lock, 0);
      bus_off = 0; timing0 = 8'h12;

      // thresholds
      thr_sel = 0; tec = 9; rec = 0; look();
      chk("R12 tec 9 low", err_exceeded, 0);
      tec = 10; look();
      chk("R12 tec 10 low", err_exceeded, 1);
      tec = 0; rec = 10; look();
      chk("R12 rec 10 low", err_exceeded, 1);
      thr_sel = 1; rec = 127; look();
      chk("R12 rec 127 high", err_exceeded, 0);
      rec = 128; look();
      chk("R12 rec 128 high", err_exceeded, 1);
      rec = 0; tec = 200; look();
      chk("R12 tec 200 high", err_exceeded, 1);
      tec = 127; look();
      chk("R12 tec 127 high", err_exceeded, 0);

      cyc(5);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

endmodule